// File: doc/BRIEF.md
# Banked Accumulator ALU Execution Unit

This block executes two kinds of 16-bit instruction word on an 8-bit accumulator datapath. One kind adds the working register, a byte taken from a banked register file and the carry flag. The other kind ANDs the working register with an 8-bit literal carried in the word. The unit holds the working register (W), a five-flag status register, a 4-bit bank select register (BSR), an 8-bit index register (IDX) and a small internal register file of general-purpose bytes. A word is handed over with a valid/ready handshake. The debug outputs show W and the flags.

Every accepted word moves through a five-state machine. IDLE holds `instr_ready` high and moves to DECODE when `instr_valid` is seen. DECODE classifies the word. For an unknown word it returns to IDLE (transition DECODE→IDLE). For a known word it forms the effective operand address and moves on (DECODE→READ). READ fetches either the register byte or the literal (READ→PROCESS). PROCESS computes the result and the new flags (PROCESS→WRITE). WRITE commits the destination and the flags, then goes back (WRITE→IDLE).

The operand address comes from one of three modes. Access mode splits the 8-bit field between low general-purpose RAM and the special-function page. Banked mode places BSR above the field. Indexed mode adds the field to IDX and applies only while `ext_mode` is high.

Top module: `accum_alu_unit`

## Requirements
- R1: After reset W, the flags, BSR and IDX are 0, `instr_ready` is 1 and `illegal_instr` is 0. The general-purpose byte at physical index p (p = bank*256 + offset) resets to (37*p + 0x5A) mod 256.
- R2: A word is taken when `instr_valid` and `instr_ready` are both high. For a recognised word `instr_ready` then stays low for exactly four cycles, and the result is on the debug outputs in the cycle where `instr_ready` is high again.
- R3: The word 0010_00da_ffff_ffff (bit 9 = d, bit 8 = a, bits 7:0 = f) computes W + operand + C modulo 256. With d=0 the sum goes to W. With d=1 it goes to the addressed register and W keeps its value.
- R4: The add sets the flags as follows. C is the carry out of bit 7. DC is the carry out of bit 3. Z is set when the result is 0. N is result bit 7. OV is set when both operands share a sign and the result's sign differs. The flag bits are C=0, DC=1, Z=2, OV=3, N=4 of `dbg_flags` and of the status byte.
- R5: The word 0000_1011_kkkk_kkkk writes W AND k into W. It updates N and Z the same way as R4 and leaves C, DC and OV unchanged.
- R6: With a=0, when indexed mode does not apply, an f below 0x60 addresses byte f of bank 0. An f of 0x60 or more addresses special-function address 0xF00+f.
- R7: With a=1 the address is {BSR, f}. A BSR of 15 selects the special-function page. Any other BSR value selects general-purpose bank (BSR mod 2).
- R8: With a=0, `ext_mode`=1 and f ≤ 0x5F, the address is IDX + f as a 12-bit sum. It is decoded as general-purpose bank (bits 11:8 mod 2) at offset bits 7:0.
- R9: The special-function page maps W at 0xFE8, the status byte at 0xFD8 (bits 7:5 read as 0), BSR at 0xFE0 (only the low 4 bits are written and read, the upper bits read as 0) and IDX at 0xFE9. Any other address on the page reads 0 and ignores writes.
- R10: When an add with d=1 targets the status address, the flag update takes priority over the written byte. The status byte afterwards holds exactly the flags from R4.
- R11: Any other word leaves W, the flags, BSR, IDX and the register file unchanged. `illegal_instr` goes high for exactly one cycle, one cycle after acceptance, and `instr_ready` is low for only that one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr_word | input | 16 | Instruction word offered to the unit |
| instr_valid | input | 1 | Word on `instr_word` is valid |
| instr_ready | output | 1 | Unit is in IDLE and accepts a word |
| ext_mode | input | 1 | Enables indexed addressing for low access addresses |
| dbg_w | output | 8 | Working register contents |
| dbg_flags | output | 5 | Flags {N, OV, Z, DC, C} |
| illegal_instr | output | 1 | One-cycle pulse for an unrecognised word |

## Verification
In WRITE, the flag commit and a destination write can hit the same register in the same cycle. This happens when an add with d=1 targets the status address (R10) or the W address (R9). The bench provokes it with directed adds to those addresses, and its random phase picks those addresses with raised weight. The behavioural model lets the flags win over the written byte, lets the sum land in W, and compares `dbg_w` and `dbg_flags` on every clock. A wrong priority shows up as a flag mismatch right after WRITE.

// File: rtl/accum_alu_pkg.sv
package accum_alu_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DECODE,
        ST_READ,
        ST_PROCESS,
        ST_WRITE
    } phase_e;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_ADDC,
        OP_ANDK
    } op_e;

    // flag order in the packed struct gives c at bit 0 up to n at bit 4
    typedef struct packed {
        logic n;
        logic ov;
        logic z;
        logic dc;
        logic c;
    } flags_t;

    localparam logic [11:0] SFR_W_ADDR      = 12'hFE8;
    localparam logic [11:0] SFR_STATUS_ADDR = 12'hFD8;
    localparam logic [11:0] SFR_BSR_ADDR    = 12'hFE0;
    localparam logic [11:0] SFR_IDX_ADDR    = 12'hFE9;
    localparam logic [3:0]  SFR_PAGE        = 4'hF;
    localparam logic [7:0]  ACCESS_SPLIT    = 8'h60;
    localparam logic [7:0]  INDEX_LIMIT     = 8'h5F;

    function automatic logic [7:0] gpr_init(input int unsigned p, input logic [7:0] seed);
        return 8'(p * 32'd37 + 32'(seed));
    endfunction

endpackage

// File: rtl/accum_decode.sv
module accum_decode
    import accum_alu_pkg::*;
(
    input  logic [15:0] word,
    output op_e         op,
    output logic        dest_f,
    output logic        bank_sel,
    output logic [7:0]  arg
);
    always_comb begin
        arg      = word[7:0];
        dest_f   = word[9];
        bank_sel = word[8];
        if (word[15:10] == 6'b001000) begin
            op = OP_ADDC;
        end else if (word[15:8] == 8'h0B) begin
            op = OP_ANDK;
        end else begin
            op = OP_NONE;
        end
    end
endmodule

// File: rtl/accum_addr_gen.sv
module accum_addr_gen
    import accum_alu_pkg::*;
(
    input  logic [7:0]  f,
    input  logic        bank_sel,
    input  logic        ext_mode,
    input  logic [3:0]  bsr,
    input  logic [7:0]  idx,
    output logic [11:0] eff_addr
);
    always_comb begin
        if (bank_sel) begin
            eff_addr = {bsr, f};
        end else if (ext_mode && (f <= INDEX_LIMIT)) begin
            eff_addr = {4'h0, idx} + {4'h0, f};
        end else if (f < ACCESS_SPLIT) begin
            eff_addr = {4'h0, f};
        end else begin
            eff_addr = {SFR_PAGE, f};
        end
    end
endmodule

// File: rtl/accum_alu.sv
module accum_alu
    import accum_alu_pkg::*;
(
    input  op_e        op,
    input  logic [7:0] w_in,
    input  logic [7:0] operand,
    input  flags_t     flags_in,
    output logic [7:0] result,
    output flags_t     flags_out
);
    logic [8:0] sum9;
    logic [4:0] nib5;

    always_comb begin
        sum9      = {1'b0, w_in} + {1'b0, operand} + {8'h00, flags_in.c};
        nib5      = {1'b0, w_in[3:0]} + {1'b0, operand[3:0]} + {4'h0, flags_in.c};
        flags_out = flags_in;
        unique case (op)
            OP_ADDC: begin
                result       = sum9[7:0];
                flags_out.c  = sum9[8];
                flags_out.dc = nib5[4];
                flags_out.ov = (w_in[7] == operand[7]) && (sum9[7] != w_in[7]);
                flags_out.n  = sum9[7];
                flags_out.z  = (sum9[7:0] == 8'h00);
            end
            OP_ANDK: begin
                result       = w_in & operand;
                flags_out.n  = result[7];
                flags_out.z  = (result == 8'h00);
            end
            default: begin
                result = 8'h00;
            end
        endcase
    end
endmodule

// File: rtl/accum_regfile.sv
module accum_regfile
    import accum_alu_pkg::*;
#(
    parameter int          BANK_CNT = 2,
    parameter logic [7:0]  SEED     = 8'h5A
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [$clog2(BANK_CNT)-1:0]   rd_bank,
    input  logic [7:0]                    rd_off,
    output logic [7:0]                    rd_data,
    input  logic                          wr_en,
    input  logic [$clog2(BANK_CNT)-1:0]   wr_bank,
    input  logic [7:0]                    wr_off,
    input  logic [7:0]                    wr_data
);
    localparam int DEPTH = BANK_CNT * 256;

    logic [7:0] mem [DEPTH];

    assign rd_data = mem[{rd_bank, rd_off}];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= gpr_init(32'(i), SEED);
            end
        end else if (wr_en) begin
            mem[{wr_bank, wr_off}] <= wr_data;
        end
    end
endmodule

// File: rtl/accum_alu_unit.sv
module accum_alu_unit
    import accum_alu_pkg::*;
#(
    parameter int         BANK_CNT  = 2,
    parameter logic [7:0] INIT_SEED = 8'h5A
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] instr_word,
    input  logic        instr_valid,
    output logic        instr_ready,
    input  logic        ext_mode,
    output logic [7:0]  dbg_w,
    output logic [4:0]  dbg_flags,
    output logic        illegal_instr
);
    localparam int BANK_BITS = $clog2(BANK_CNT);

    phase_e state_q, state_d;

    logic [15:0] word_q;
    op_e         op_dec, op_q;
    logic        dest_dec, bsel_dec, dest_q;
    logic [7:0]  arg_dec, arg_q;
    logic [11:0] ea_dec, ea_q;
    logic [7:0]  operand_q, result_q, alu_res;
    flags_t      status_q, flags_q, alu_flags;
    logic [7:0]  w_q, idx_q;
    logic [3:0]  bsr_q;
    logic        illegal_q;

    logic        is_sfr;
    logic [7:0]  sfr_rd, gpr_rd, rd_val;
    logic        gpr_we;

    accum_decode u_decode (
        .word     (word_q),
        .op       (op_dec),
        .dest_f   (dest_dec),
        .bank_sel (bsel_dec),
        .arg      (arg_dec)
    );

    accum_addr_gen u_addr (
        .f        (arg_dec),
        .bank_sel (bsel_dec),
        .ext_mode (ext_mode),
        .bsr      (bsr_q),
        .idx      (idx_q),
        .eff_addr (ea_dec)
    );

    accum_alu u_alu (
        .op        (op_q),
        .w_in      (w_q),
        .operand   (operand_q),
        .flags_in  (status_q),
        .result    (alu_res),
        .flags_out (alu_flags)
    );

    assign is_sfr = (ea_q[11:8] == SFR_PAGE);
    assign gpr_we = (state_q == ST_WRITE) && (op_q == OP_ADDC) && dest_q && !is_sfr;

    accum_regfile #(
        .BANK_CNT (BANK_CNT),
        .SEED     (INIT_SEED)
    ) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_bank (ea_q[8 +: BANK_BITS]),
        .rd_off  (ea_q[7:0]),
        .rd_data (gpr_rd),
        .wr_en   (gpr_we),
        .wr_bank (ea_q[8 +: BANK_BITS]),
        .wr_off  (ea_q[7:0]),
        .wr_data (result_q)
    );

    always_comb begin
        case (ea_q)
            SFR_W_ADDR:      sfr_rd = w_q;
            SFR_STATUS_ADDR: sfr_rd = {3'b000, status_q};
            SFR_BSR_ADDR:    sfr_rd = {4'h0, bsr_q};
            SFR_IDX_ADDR:    sfr_rd = idx_q;
            default:         sfr_rd = 8'h00;
        endcase
        rd_val = is_sfr ? sfr_rd : gpr_rd;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (instr_valid) state_d = ST_DECODE;
            ST_DECODE:  state_d = (op_dec == OP_NONE) ? ST_IDLE : ST_READ;
            ST_READ:    state_d = ST_PROCESS;
            ST_PROCESS: state_d = ST_WRITE;
            ST_WRITE:   state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // datapath per phase
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q    <= 16'h0000;
            op_q      <= OP_NONE;
            dest_q    <= 1'b0;
            arg_q     <= 8'h00;
            ea_q      <= 12'h000;
            operand_q <= 8'h00;
            result_q  <= 8'h00;
            flags_q   <= '0;
            status_q  <= '0;
            w_q       <= 8'h00;
            bsr_q     <= 4'h0;
            idx_q     <= 8'h00;
            illegal_q <= 1'b0;
        end else begin
            illegal_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (instr_valid) word_q <= instr_word;
                end
                ST_DECODE: begin
                    if (op_dec == OP_NONE) begin
                        illegal_q <= 1'b1;
                    end else begin
                        op_q   <= op_dec;
                        dest_q <= dest_dec && (op_dec == OP_ADDC);
                        arg_q  <= arg_dec;
                        ea_q   <= ea_dec;
                    end
                end
                ST_READ: begin
                    operand_q <= (op_q == OP_ANDK) ? arg_q : rd_val;
                end
                ST_PROCESS: begin
                    result_q <= alu_res;
                    flags_q  <= alu_flags;
                end
                ST_WRITE: begin
                    // flags are committed last in priority: a status-address
                    // destination never overrides them
                    status_q <= flags_q;
                    if (!dest_q) begin
                        w_q <= result_q;
                    end else if (is_sfr) begin
                        case (ea_q)
                            SFR_W_ADDR:   w_q   <= result_q;
                            SFR_BSR_ADDR: bsr_q <= result_q[3:0];
                            SFR_IDX_ADDR: idx_q <= result_q;
                            default: ;
                        endcase
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        instr_ready   = (state_q == ST_IDLE);
        dbg_w         = w_q;
        dbg_flags     = status_q;
        illegal_instr = illegal_q;
    end

endmodule

// File: rtl/accum_alu_unit_chk.sv
module accum_alu_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        instr_valid,
    input logic        instr_ready,
    input logic [15:0] instr_word,
    input logic        illegal_instr,
    input logic [7:0]  dbg_w,
    input logic [4:0]  dbg_flags
);
    logic [15:0] acc_word;
    logic [4:0]  acc_flags;
    logic [2:0]  busy_cnt;
    logic        acc_is_and, acc_is_add;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_word  <= 16'h0000;
            acc_flags <= 5'h00;
            busy_cnt  <= 3'd0;
        end else begin
            if (instr_valid && instr_ready) begin
                acc_word  <= instr_word;
                acc_flags <= dbg_flags;
            end
            if (instr_ready) busy_cnt <= 3'd0;
            else if (busy_cnt != 3'd7) busy_cnt <= busy_cnt + 3'd1;
        end
    end

    assign acc_is_and = (acc_word[15:8] == 8'h0B);
    assign acc_is_add = (acc_word[15:10] == 6'b001000) && !acc_word[9];

    p_ready_drops_r2: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid && instr_ready |=> !instr_ready);

    p_busy_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy_cnt <= 3'd4);

    p_illegal_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_instr |=> !illegal_instr);

    p_illegal_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_instr |-> $stable(dbg_w) && $stable(dbg_flags));

    p_and_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(instr_ready) && acc_is_and |->
            dbg_flags[0] == acc_flags[0] && dbg_flags[1] == acc_flags[1] &&
            dbg_flags[3] == acc_flags[3] && dbg_flags[4] == dbg_w[7] &&
            dbg_flags[2] == (dbg_w == 8'h00));

    p_add_nz_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(instr_ready) && acc_is_add |->
            dbg_flags[4] == dbg_w[7] && dbg_flags[2] == (dbg_w == 8'h00));

endmodule

bind accum_alu_unit accum_alu_unit_chk chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .instr_valid   (instr_valid),
    .instr_ready   (instr_ready),
    .instr_word    (instr_word),
    .illegal_instr (illegal_instr),
    .dbg_w         (dbg_w),
    .dbg_flags     (dbg_flags)
);

// File: tb/accum_alu_unit_tb_top.sv
`timescale 1ns/1ps
module accum_alu_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] instr_word = 16'h0000;
    logic        instr_valid = 1'b0;
    logic        ext_mode = 1'b0;
    logic        instr_ready;
    logic [7:0]  dbg_w;
    logic [4:0]  dbg_flags;
    logic        illegal_instr;

    always #2.5 clk = ~clk;

    accum_alu_unit dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .instr_word    (instr_word),
        .instr_valid   (instr_valid),
        .instr_ready   (instr_ready),
        .ext_mode      (ext_mode),
        .dbg_w         (dbg_w),
        .dbg_flags     (dbg_flags),
        .illegal_instr (illegal_instr)
    );

    int    checks = 0;
    int    fails  = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    // ---------------- reference model ----------------
    logic [7:0]  m_w, m_idx;
    logic [4:0]  m_flags;          // {N, OV, Z, DC, C}
    logic [3:0]  m_bsr;
    logic [7:0]  m_mem [0:511];
    logic        m_ready, m_illegal;
    logic [15:0] m_pend;
    int          m_cnt;

    function automatic bit is_add(input logic [15:0] wd);
        return wd[15:10] == 6'b001000;
    endfunction
    function automatic bit is_and(input logic [15:0] wd);
        return wd[15:8] == 8'h0B;
    endfunction

    task automatic model_reset();
        m_w = 8'h00; m_idx = 8'h00; m_flags = 5'h00; m_bsr = 4'h0;
        m_ready = 1'b1; m_illegal = 1'b0; m_pend = 16'h0000; m_cnt = 0;
        for (int i = 0; i < 512; i++) m_mem[i] = 8'((i * 37 + 'h5A) % 256);
    endtask

    function automatic logic [7:0] model_read(input int ea);
        if (ea >= 'hF00) begin
            if (ea == 'hFE8) return m_w;
            if (ea == 'hFD8) return {3'b000, m_flags};
            if (ea == 'hFE0) return {4'h0, m_bsr};
            if (ea == 'hFE9) return m_idx;
            return 8'h00;
        end
        return m_mem[((ea / 256) % 2) * 256 + (ea % 256)];
    endfunction

    task automatic model_exec(input logic [15:0] wd);
        logic [7:0] res, opnd, f;
        int ea, sum, cin;
        if (is_and(wd)) begin
            res = m_w & wd[7:0];
            m_w = res;
            m_flags[4] = res[7];
            m_flags[2] = (res == 8'h00);
        end else begin
            f = wd[7:0];
            if (!wd[8] && ext_mode && f <= 8'h5F) ea = int'(m_idx) + int'(f);
            else if (!wd[8]) ea = (f < 8'h60) ? int'(f) : 'hF00 + int'(f);
            else ea = int'(m_bsr) * 256 + int'(f);
            opnd = model_read(ea);
            cin = int'(m_flags[0]);
            sum = int'(m_w) + int'(opnd) + cin;
            res = 8'(sum % 256);
            m_flags[0] = (sum > 255);
            m_flags[1] = ((int'(m_w) % 16) + (int'(opnd) % 16) + cin) > 15;
            m_flags[2] = (res == 8'h00);
            m_flags[3] = (m_w[7] == opnd[7]) && (res[7] != m_w[7]);
            m_flags[4] = res[7];
            if (!wd[9]) m_w = res;
            else if (ea >= 'hF00) begin
                if (ea == 'hFE8) m_w = res;
                else if (ea == 'hFE0) m_bsr = res[3:0];
                else if (ea == 'hFE9) m_idx = res;
            end else begin
                m_mem[((ea / 256) % 2) * 256 + (ea % 256)] = res;
            end
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            model_reset();
        end else begin
            logic new_ill;
            new_ill = 1'b0;
            if (m_ready) begin
                if (instr_valid) begin
                    m_pend = instr_word; m_cnt = 1; m_ready = 1'b0;
                end
            end else if (m_cnt == 1 && !is_add(m_pend) && !is_and(m_pend)) begin
                new_ill = 1'b1; m_ready = 1'b1;
            end else if (m_cnt == 4) begin
                model_exec(m_pend); m_ready = 1'b1;
            end else begin
                m_cnt++;
            end
            m_illegal = new_ill;
        end
    end

    // ---------------- checking ----------------
    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: %s actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(cur_req, "W", int'(dbg_w), int'(m_w));
            check(cur_req, "flags", int'(dbg_flags), int'(m_flags));
            check("R2", "ready", int'(instr_ready), int'(m_ready));
            check("R11", "illegal", int'(illegal_instr), int'(m_illegal));
        end
    end

    task automatic issue(input logic [15:0] wd, input logic ext, input string tag);
        @(negedge clk);
        while (!instr_ready) @(negedge clk);
        cur_req = tag; ext_mode = ext; instr_word = wd; instr_valid = 1'b1;
        @(negedge clk);
        instr_valid = 1'b0;
        while (!instr_ready) @(negedge clk);
    endtask

    function automatic logic [15:0] addc(input logic d, input logic a, input logic [7:0] f);
        return {6'b001000, d, a, f};
    endfunction
    function automatic logic [15:0] andk(input logic [7:0] k);
        return {8'h0B, k};
    endfunction

    task automatic finish_run();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #750000;
        checks++; fails++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        logic [15:0] lfsr;
        logic [15:0] wd;
        logic [7:0]  f;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "reset W", int'(dbg_w), 0);
        check("R1", "reset flags", int'(dbg_flags), 0);
        check("R1", "reset ready", int'(instr_ready), 1);
        check("R1", "reset illegal", int'(illegal_instr), 0);

        issue(addc(0, 0, 8'h10), 0, "R1");      // reset content of byte 0x10
        check("R1", "gpr 0x10 via W", int'(dbg_w), 'hAA);
        issue(andk(8'h00), 0, "R5");
        check("R5", "and to zero Z", int'(dbg_flags), 5'b00100);
        issue(addc(0, 0, 8'h55), 0, "R6");
        check("R6", "access byte 0x55", int'(dbg_w), 'hA3);
        issue(andk(8'h5F), 0, "R5");
        check("R5", "A3 and 5F", int'(dbg_w), 'h03);
        issue(andk(8'h00), 0, "R5");
        issue(addc(0, 0, 8'h55), 0, "R3");
        issue(addc(0, 0, 8'h10), 0, "R4");      // A3 + AA = 14D
        check("R4", "sum W", int'(dbg_w), 'h4D);
        check("R4", "C and OV set", int'(dbg_flags), 5'b01001);
        issue(andk(8'hFF), 0, "R5");
        check("R5", "C DC OV kept", int'(dbg_flags), 5'b01001);
        issue(addc(0, 1, 8'h88), 0, "R3");      // 4D + 02 + 1
        check("R3", "add with carry W", int'(dbg_w), 'h50);
        check("R4", "carry cleared DC set", int'(dbg_flags), 5'b00010);
        issue(andk(8'h00), 0, "R3");
        issue(addc(0, 1, 8'h88), 0, "R3");
        check("R3", "register unchanged", int'(dbg_w), 'h02);
        issue(addc(1, 1, 8'h88), 0, "R3");      // reg = 2+2
        check("R3", "d=1 keeps W", int'(dbg_w), 'h02);
        issue(andk(8'h00), 0, "R3");
        issue(addc(0, 1, 8'h88), 0, "R3");
        check("R3", "d=1 wrote register", int'(dbg_w), 'h04);
        issue(addc(1, 0, 8'hE0), 0, "R9");      // BSR = 4
        issue(andk(8'h00), 0, "R9");
        issue(addc(0, 0, 8'hE0), 0, "R9");
        check("R9", "BSR read back", int'(dbg_w), 'h04);
        issue(andk(8'h00), 0, "R7");
        issue(addc(0, 1, 8'h88), 0, "R7");      // bank 4 aliases bank 0
        check("R7", "bank alias", int'(dbg_w), 'h04);
        issue(addc(1, 0, 8'hE9), 0, "R8");      // IDX = 4
        issue(andk(8'h00), 0, "R8");
        issue(addc(0, 0, 8'h0C), 1, "R8");      // IDX+0x0C = 0x10
        check("R8", "indexed read", int'(dbg_w), 'hAA);
        issue(addc(1, 0, 8'hD8), 0, "R10");
        issue(addc(1, 0, 8'hE8), 0, "R9");
        issue(16'hFFFF, 0, "R11");
        issue(16'h2C00, 0, "R11");
        issue(16'h0A55, 1, "R11");

        lfsr = 16'hACE1;
        for (int n = 0; n < 400; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            f = lfsr[7:0];
            if (lfsr[13:12] == 2'b11) begin
                unique case (lfsr[1:0])
                    2'd0: f = 8'hE8;
                    2'd1: f = 8'hD8;
                    2'd2: f = 8'hE0;
                    default: f = 8'hE9;
                endcase
            end
            unique case (lfsr[10:8])
                3'd6:    wd = andk(lfsr[15:8] ^ lfsr[7:0]);
                3'd7:    wd = {4'hF, lfsr[11:0]};
                default: wd = addc(lfsr[14], lfsr[11], f);
            endcase
            issue(wd, lfsr[15] ^ lfsr[3], (lfsr[13:12] == 2'b11) ? "R10" : "R6");
        end
        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule